// File: doc/BRIEF.md
# Top-Level Interrupt Request Unit

This block produces the highest-priority interrupt request of a small microcontroller core. The request comes from one of two sources. The first is an external interrupt pin that is sampled asynchronously, with a choice of rising or falling edge. The second is a one-cycle end-of-count pulse from the timer/watchdog. The selected event latches a pending flag. The flag becomes a request through one of two enables. The maskable enable works only together with the core's global interrupt enable. The non-maskable enable is set-only: once set, it lets the request through regardless of the global enable, and only reset clears it.

When the core acknowledges the request, the block clears the pending flag and marks the top-level service routine as active. While the routine is active, the block raises an output that blocks every other interrupt and DMA grant. It also holds back any new top-level request until the core signals the return. The global enable is an input only and is never changed by entering or leaving service. A configuration register is written over a simple register-bus strobe and can be read back.

Top module: `tli_unit`

## Requirements
- R1: After reset the read-back value is 8'h01: source select (bit 0) is 1 and all other bits are 0. No request is raised and the block-all output is low.
- R2: With source select at 1, only pin edges set the pending bit (bit 4). With source select at 0, only the watchdog end-of-count pulse sets it, and pin edges are ignored.
- R3: The pin passes through a two-flop synchronizer. The edge-select bit (bit 1) chooses the edge: 1 for rising, 0 for falling. A pin change driven before clock edge k shows as pending after edge k+2 and not before.
- R4: An end-of-count pulse sampled at an edge, with source select at 0, shows as pending after that same edge.
- R5: With the non-maskable enable clear, the request is high exactly when three things hold: pending is set, the maskable enable (bit 2) is set, and the global enable input is high. This holds while no service routine is active.
- R6: The non-maskable enable (bit 3) is set by writing 1 to it, and a write of 0 leaves it set. While it is set, a pending flag raises the request whatever the global enable is.
- R7: A register write with bit 5 set loads pending from write bit 4. An acknowledge clears pending. A trigger event in the same cycle as an acknowledge or a pending write leaves pending at 1.
- R8: An acknowledge sets the service-active flag (read-back bit 5, block-all output), and a return strobe without an acknowledge clears it. While the flag is set, the request is low. A pending flag latched during service raises the request after the return.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_pin | input | 1 | Asynchronous external interrupt pin |
| wdog_eoc | input | 1 | One-cycle timer/watchdog end-of-count pulse |
| gie | input | 1 | Global interrupt enable from the core |
| ctl_we | input | 1 | Configuration write strobe |
| ctl_wdata | input | 8 | Write data: bit0 source, bit1 edge, bit2 mask enable, bit3 non-maskable set, bit4 pending value, bit5 pending load |
| ack | input | 1 | Core acknowledge of the top-level request |
| iret | input | 1 | Core return from the top-level routine |
| tl_req | output | 1 | Top-level interrupt request |
| block_all | output | 1 | Service active: block all other grants |
| ctl_rdata | output | 8 | Read-back: {2'b0, service, pending, non-maskable, mask enable, edge, source} |

## Verification
On every cycle the assertions check four things. The request is always backed by a pending flag and by a valid enable path. The request stays low while the block-all output is high. The non-maskable enable never falls outside reset. An acknowledge always enters service and a lone return always leaves it. Other behaviour needs the bench's scenarios: the exact two-cycle synchronizer latency, the choice between rising and falling edges, the ignoring of the unselected source, and which event wins when a trigger meets an acknowledge or a software write in the same cycle. The bench covers these with directed sequences and with a long random run against a cycle model.

// File: rtl/tli_pkg.sv
package tli_pkg;
    localparam int CTL_W      = 8;
    localparam int BIT_SRC    = 0;
    localparam int BIT_RISE   = 1;
    localparam int BIT_MASK   = 2;
    localparam int BIT_NMSK   = 3;
    localparam int BIT_PVAL   = 4;
    localparam int BIT_PLOAD  = 5;

    typedef struct packed {
        logic nm_en;
        logic mask_en;
        logic rise_edge;
        logic src_pin;
    } tli_cfg_t;

    localparam tli_cfg_t CFG_RESET = '{nm_en: 1'b0, mask_en: 1'b0,
                                       rise_edge: 1'b0, src_pin: 1'b1};

    function automatic logic pick_trigger(tli_cfg_t c, logic rise, logic fall,
                                          logic eoc);
        if (c.src_pin)
            return c.rise_edge ? rise : fall;
        return eoc;
    endfunction
endpackage

// File: rtl/tli_edge_det.sv
module tli_edge_det #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin,
    output logic rise,
    output logic fall
);
    localparam int LAST = SYNC_STAGES - 1;

    logic [LAST:0] sync_q;
    logic          prev_q;

    generate
        if (SYNC_STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) sync_q <= '0;
                else     sync_q <= pin;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (rst) sync_q <= '0;
                else     sync_q <= {sync_q[LAST-1:0], pin};
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= sync_q[LAST];
    end

    assign rise = sync_q[LAST] & ~prev_q;
    assign fall = ~sync_q[LAST] & prev_q;
endmodule

// File: rtl/tli_ctl.sv
module tli_ctl
    import tli_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [CTL_W-1:0] wdata,
    output tli_cfg_t         cfg
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= CFG_RESET;
        end else if (we) begin
            cfg.src_pin   <= wdata[BIT_SRC];
            cfg.rise_edge <= wdata[BIT_RISE];
            cfg.mask_en   <= wdata[BIT_MASK];
            // set-only: a zero write keeps the current value
            cfg.nm_en     <= cfg.nm_en | wdata[BIT_NMSK];
        end
    end
endmodule

// File: rtl/tli_pend.sv
module tli_pend (
    input  logic clk,
    input  logic rst,
    input  logic trig,
    input  logic sw_load,
    input  logic sw_val,
    input  logic ack,
    input  logic iret,
    output logic pend,
    output logic svc
);
    always_ff @(posedge clk) begin
        if (rst)          pend <= 1'b0;
        else if (trig)    pend <= 1'b1;
        else if (sw_load) pend <= sw_val;
        else if (ack)     pend <= 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst)       svc <= 1'b0;
        else if (ack)  svc <= 1'b1;
        else if (iret) svc <= 1'b0;
    end
endmodule

// File: rtl/tli_unit.sv
module tli_unit
    import tli_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ext_pin,
    input  logic             wdog_eoc,
    input  logic             gie,
    input  logic             ctl_we,
    input  logic [CTL_W-1:0] ctl_wdata,
    input  logic             ack,
    input  logic             iret,
    output logic             tl_req,
    output logic             block_all,
    output logic [CTL_W-1:0] ctl_rdata
);
    tli_cfg_t cfg;
    logic     pin_rise, pin_fall, trig, pend, svc;

    tli_edge_det #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk(clk), .rst(rst), .pin(ext_pin), .rise(pin_rise), .fall(pin_fall)
    );

    tli_ctl u_ctl (
        .clk(clk), .rst(rst), .we(ctl_we), .wdata(ctl_wdata), .cfg(cfg)
    );

    assign trig = pick_trigger(cfg, pin_rise, pin_fall, wdog_eoc);

    tli_pend u_pend (
        .clk(clk), .rst(rst), .trig(trig),
        .sw_load(ctl_we & ctl_wdata[BIT_PLOAD]),
        .sw_val(ctl_wdata[BIT_PVAL]),
        .ack(ack), .iret(iret), .pend(pend), .svc(svc)
    );

    assign tl_req    = pend & ~svc & (cfg.nm_en | (cfg.mask_en & gie));
    assign block_all = svc;
    assign ctl_rdata = {2'b00, svc, pend, cfg.nm_en, cfg.mask_en,
                        cfg.rise_edge, cfg.src_pin};
endmodule

// File: rtl/tli_unit_chk.sv
module tli_unit_chk (
    input logic       clk,
    input logic       rst,
    input logic       wdog_eoc,
    input logic       gie,
    input logic       ack,
    input logic       iret,
    input logic       tl_req,
    input logic       block_all,
    input logic [7:0] ctl_rdata
);
    assert_req_backed_R5: assert property (@(posedge clk) disable iff (rst)
        tl_req |-> (ctl_rdata[4] && (ctl_rdata[3] || (ctl_rdata[2] && gie))));

    assert_no_req_in_service_R8: assert property (@(posedge clk) disable iff (rst)
        block_all |-> !tl_req);

    assert_ack_enters_R8: assert property (@(posedge clk) disable iff (rst)
        ack |=> block_all);

    assert_iret_leaves_R8: assert property (@(posedge clk) disable iff (rst)
        (iret && !ack) |=> !block_all);

    assert_nm_sticky_R6: assert property (@(posedge clk) disable iff (rst)
        ctl_rdata[3] |=> ctl_rdata[3]);

    assert_eoc_sets_R4: assert property (@(posedge clk) disable iff (rst)
        (wdog_eoc && !ctl_rdata[0]) |=> ctl_rdata[4]);
endmodule

bind tli_unit tli_unit_chk u_chk (
    .clk(clk), .rst(rst), .wdog_eoc(wdog_eoc), .gie(gie), .ack(ack),
    .iret(iret), .tl_req(tl_req), .block_all(block_all), .ctl_rdata(ctl_rdata)
);

// File: tb/tli_unit_bench.sv
module tli_unit_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ext_pin = 1'b0, wdog_eoc = 1'b0, gie = 1'b0;
    logic       ctl_we = 1'b0, ack = 1'b0, iret = 1'b0;
    logic [7:0] ctl_wdata = 8'h00;
    logic       tl_req, block_all;
    logic [7:0] ctl_rdata;

    int checks = 0;
    int errors = 0;

    // bench cycle model
    bit m_s1, m_s2, m_pv, m_pend, m_svc, m_src, m_rise, m_men, m_nm;

    always #5 clk = ~clk;

    tli_unit u_tli_unit (
        .clk(clk), .rst(rst), .ext_pin(ext_pin), .wdog_eoc(wdog_eoc),
        .gie(gie), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .ack(ack),
        .iret(iret), .tl_req(tl_req), .block_all(block_all),
        .ctl_rdata(ctl_rdata)
    );

    function automatic bit exp_req();
        return m_pend & ~m_svc & (m_nm | (m_men & gie));
    endfunction

    function automatic logic [7:0] exp_rd();
        return {2'b00, m_svc, m_pend, m_nm, m_men, m_rise, m_src};
    endfunction

    task automatic model_update();
        bit evt;
        if (rst) begin
            m_s1 = 0; m_s2 = 0; m_pv = 0; m_pend = 0; m_svc = 0;
            m_src = 1; m_rise = 0; m_men = 0; m_nm = 0;
            return;
        end
        if (m_src) evt = m_rise ? (m_s2 & ~m_pv) : (~m_s2 & m_pv);
        else       evt = wdog_eoc;
        if (evt)                        m_pend = 1;
        else if (ctl_we && ctl_wdata[5]) m_pend = ctl_wdata[4];
        else if (ack)                   m_pend = 0;
        if (ack)       m_svc = 1;
        else if (iret) m_svc = 0;
        if (ctl_we) begin
            m_src = ctl_wdata[0]; m_rise = ctl_wdata[1];
            m_men = ctl_wdata[2]; m_nm = m_nm | ctl_wdata[3];
        end
        m_pv = m_s2; m_s2 = m_s1; m_s1 = ext_pin;
    endtask

    task automatic chk(string tag, string what, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        model_update();
        @(negedge clk);
        ctl_we = 0; ack = 0; iret = 0; wdog_eoc = 0;
    endtask

    task automatic cmp(string tag);
        chk(tag, "tl_req", {7'd0, tl_req}, {7'd0, exp_req()});
        chk(tag, "block_all", {7'd0, block_all}, {7'd0, m_svc});
        chk(tag, "rdata", ctl_rdata, exp_rd());
    endtask

    task automatic wr(logic [7:0] d);
        ctl_we = 1; ctl_wdata = d;
        step();
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h1234_5678));
        @(negedge clk);
        step(); step();
        rst = 0;
        step();
        // R1 reset state
        chk("R1", "rdata", ctl_rdata, 8'h01);
        chk("R1", "tl_req", {7'd0, tl_req}, 8'h00);
        chk("R1", "block_all", {7'd0, block_all}, 8'h00);

        // R5 / R4 watchdog source, maskable path
        wr(8'h04);
        chk("R5", "rdata", ctl_rdata, 8'h04);
        wdog_eoc = 1; step();
        chk("R4", "rdata", ctl_rdata, 8'h14);
        chk("R5", "tl_req gie0", {7'd0, tl_req}, 8'h00);
        gie = 1; #1;
        chk("R5", "tl_req gie1", {7'd0, tl_req}, 8'h01);

        // R8 service entry, event during service, return
        ack = 1; step();
        chk("R8", "rdata ack", ctl_rdata, 8'h24);
        chk("R8", "block_all", {7'd0, block_all}, 8'h01);
        wdog_eoc = 1; step();
        chk("R8", "rdata svc pend", ctl_rdata, 8'h34);
        chk("R8", "tl_req in svc", {7'd0, tl_req}, 8'h00);
        iret = 1; step();
        chk("R8", "rdata iret", ctl_rdata, 8'h14);
        chk("R8", "tl_req after iret", {7'd0, tl_req}, 8'h01);
        ack = 1; step(); iret = 1; step();
        chk("R8", "rdata idle", ctl_rdata, 8'h04);

        // R2 pin ignored while watchdog selected
        ext_pin = 1; step(); step(); step(); step();
        chk("R2", "pin ignored", ctl_rdata, 8'h04);
        ext_pin = 0; step(); step(); step();

        // R3 rising edge latency
        wr(8'h07);
        ext_pin = 1; step(); step();
        chk("R3", "rise not yet", ctl_rdata, 8'h07);
        step();
        chk("R3", "rise pending", ctl_rdata, 8'h17);
        wr(8'h27);
        chk("R7", "sw clear", ctl_rdata, 8'h07);
        wr(8'h25);
        ext_pin = 0; step(); step();
        chk("R3", "fall not yet", ctl_rdata, 8'h05);
        step();
        chk("R3", "fall pending", ctl_rdata, 8'h15);

        // R7 software set, trigger beats ack
        wr(8'h25);
        wr(8'h35);
        chk("R7", "sw set", ctl_rdata, 8'h15);
        wr(8'h04);
        chk("R7", "cfg write keeps pend", ctl_rdata, 8'h14);
        ack = 1; wdog_eoc = 1; step();
        chk("R7", "trig with ack", ctl_rdata, 8'h34);
        iret = 1; step();
        chk("R7", "after iret", ctl_rdata, 8'h14);
        ctl_we = 1; ctl_wdata = 8'h24; wdog_eoc = 1; step();
        chk("R7", "trig with sw clear", ctl_rdata, 8'h14);

        // R6 set-only non-maskable enable bypasses gie
        gie = 0;
        wr(8'h08);
        chk("R6", "nm set", ctl_rdata, 8'h18);
        chk("R6", "tl_req gie0", {7'd0, tl_req}, 8'h01);
        wr(8'h00);
        chk("R6", "nm zero write", ctl_rdata, 8'h18);
        wr(8'h20);
        chk("R6", "cleared pend nm kept", ctl_rdata, 8'h08);
        cmp("R2");

        // random run against the model
        for (int i = 0; i < 4000; i++) begin
            ext_pin  = ($urandom % 4) == 0 ? ~ext_pin : ext_pin;
            wdog_eoc = ($urandom % 6) == 0;
            gie      = $urandom % 2;
            ack      = ($urandom % 8) == 0;
            iret     = ($urandom % 6) == 0;
            ctl_we   = ($urandom % 7) == 0;
            ctl_wdata = 8'($urandom) & ((($urandom % 4) == 0) ? 8'h3f : 8'h37);
            rst      = ($urandom % 500) == 0;
            step();
            rst = 0;
            cmp(m_src ? "R3" : "R4");
            cmp(m_nm ? "R6" : "R5");
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule